// File: doc/BRIEF.md
# Sentinel-Terminated Serial Transmitter

This block sends one asynchronous serial character per write. A strobe captures a data byte and, when the nine-bit format is selected, an extra programmable bit. The transmitter places the character on a single output line: first a low start bit, then the data bits least significant first, then the optional ninth bit, and finally a high stop level. Bit timing comes from an external tick that runs at sixteen times the baud rate. An internal four-bit divider counts these ticks freely. Every wrap of the divider marks a bit boundary, and a character always starts on such a boundary rather than on the write.

The end of a character is not found by counting bits. A single marker bit sits in a shift register whose unused positions are zero. In the eight-bit format the marker is preloaded above the byte. In the nine-bit format the first shift inserts it. Once the last payload bit is at the output and the marker sits just above it, with nothing else set, the next boundary performs one final shift, returns the line to idle and raises a done flag. That flag stays high until the clear input is pulsed.

Top module: `sentinel_uart_tx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `txd` is 1 and `tx_done` is 0.
- R2: `txd` is 1 whenever no character is being sent, including while a write waits for its first boundary and after the final boundary of a character, which leaves the stop level on the line.
- R3: A rollover is a cycle in which `baud_tick` is high and the divider holds 15. The divider counts from 0 after reset, so every 16th tick is a rollover. `txd` changes only in the cycle after a rollover. The start bit (0) appears in the cycle after the first rollover that follows the write cycle. A rollover in the write cycle itself does not count.
- R4: With `nine_bit_mode` = 0 at the write, the levels after rollovers 1 to 10 are 0, then `wr_byte` bits 0 through 7, then 1.
- R5: With `nine_bit_mode` = 1 at the write, the levels after rollovers 1 to 11 are 0, then `wr_byte` bits 0 through 7, then `wr_ninth`, then 1. This holds even when the payload, before the first shift, already looks like the end pattern.
- R6: `tx_done` rises in the cycle after the 10th rollover after the write in the eight-bit format, or after the 11th in the nine-bit format, and not before.
- R7: `tx_done` stays at 1 until `done_clr` is high in a cycle, and then it reads 0 in the next cycle. If a character completes in the same cycle as a clear, the flag is set.
- R8: A write that arrives while a character is waiting or in progress is ignored. The character in flight keeps its content and length, and no further character follows it.
- R9: The format and the ninth bit are captured at the accepted write. Later changes on `nine_bit_mode` or `wr_ninth` do not affect the character in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse at sixteen times the baud rate |
| wr_stb | input | 1 | Write strobe for a new character |
| wr_byte | input | DATA_W | Data byte, sent least significant bit first |
| wr_ninth | input | 1 | Ninth payload bit used in the nine-bit format |
| nine_bit_mode | input | 1 | 1 selects the 11-bit character, 0 the 10-bit character |
| done_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output line, idle high |
| tx_done | output | 1 | Done flag for the last character |

## Verification
The embedded properties assume only that reset is applied at start-up. They place no constraint on how often `baud_tick` pulses, and strobes, clears and mode changes may arrive in any cycle, including cycles that are also rollovers. The stimulus keeps within that envelope while still exercising it. It varies tick density from sparse to every cycle, injects stray writes and mode flips throughout a character, and holds the clear high across one completion. It also places a write on a rollover cycle, and it sends a nine-bit payload whose raw register image matches the end pattern. Each line level is compared with a bench function of the captured byte, ninth bit, format and rollover index, at the cycle that follows each rollover.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_START,
        PH_DATA
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   nine;
        logic   shifted;
        logic   txd;
        logic   done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{phase: PH_IDLE, nine: 1'b0, shifted: 1'b0,
                                 txd: 1'b1, done: 1'b0};

endpackage

// File: rtl/stx_baud_div.sv
module stx_baud_div #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic roll
);
    localparam logic [DIV_W-1:0] CNT_LAST = '1;

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign roll = tick && (cnt_q == CNT_LAST);

    // bit boundary restarts the sixteenths of the next bit
    assert_bit_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> (cnt_q == '0));

    // divider advances only on ticks
    assert_tick_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q));

endmodule

// File: rtl/stx_sentinel_sr.sv
module stx_sentinel_sr #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic              mark_in,
    input  logic [DATA_W:0]   load_word,
    output logic              line_bit,
    output logic              next_bit,
    output logic              at_end
);
    localparam int SR_W = DATA_W + 1;
    localparam logic [SR_W-2:0] END_PAT = (SR_W-1)'(1);

    logic [SR_W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = load_word;
        end else if (shift) begin
            sr_d = {mark_in, sr_q[SR_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign line_bit = sr_q[0];
    assign next_bit = sr_q[1];
    // marker right above the output bit, all higher positions empty
    assign at_end   = (sr_q[SR_W-1:1] == END_PAT);

    // contents only move on a load or a shift
    assert_sr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(sr_q));

endmodule

// File: rtl/sentinel_uart_tx.sv
module sentinel_uart_tx #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              wr_ninth,
    input  logic              nine_bit_mode,
    input  logic              done_clr,
    output logic              txd,
    output logic              tx_done
);
    import stx_pkg::*;

    localparam int SR_W = DATA_W + 1;

    logic            roll;
    logic            line_bit;
    logic            next_bit;
    logic            at_end;
    logic            sr_load;
    logic            sr_shift;
    logic            mark;
    logic [SR_W-1:0] load_word;
    ctl_t            s_d, s_q;

    stx_baud_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (baud_tick),
        .roll (roll)
    );

    stx_sentinel_sr #(.DATA_W(DATA_W)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sr_load),
        .shift    (sr_shift),
        .mark_in  (mark),
        .load_word(load_word),
        .line_bit (line_bit),
        .next_bit (next_bit),
        .at_end   (at_end)
    );

    // eight-bit format preloads the marker; nine-bit loads the extra bit
    assign load_word = {(nine_bit_mode ? wr_ninth : 1'b1), wr_byte};

    always_comb begin
        s_d      = s_q;
        sr_load  = 1'b0;
        sr_shift = 1'b0;
        mark     = 1'b0;
        if (done_clr) begin
            s_d.done = 1'b0;
        end
        case (s_q.phase)
            PH_IDLE: begin
                if (wr_stb) begin
                    s_d.phase   = PH_WAIT;
                    s_d.nine    = nine_bit_mode;
                    s_d.shifted = 1'b0;
                    sr_load     = 1'b1;
                end
            end
            PH_WAIT: begin
                if (roll) begin
                    s_d.phase = PH_START;
                    s_d.txd   = 1'b0;
                end
            end
            PH_START: begin
                if (roll) begin
                    s_d.phase = PH_DATA;
                    s_d.txd   = line_bit;
                end
            end
            PH_DATA: begin
                if (roll) begin
                    sr_shift = 1'b1;
                    mark     = s_q.nine && !s_q.shifted;
                    if (s_q.shifted && at_end) begin
                        s_d.phase = PH_IDLE;
                        s_d.txd   = 1'b1;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.shifted = 1'b1;
                        s_d.txd     = next_bit;
                    end
                end
            end
            default: begin
                s_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= CTL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign txd     = s_q.txd;
    assign tx_done = s_q.done;

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE || s_q.phase == PH_WAIT) |-> txd);

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_WAIT && roll) |=> !txd);

    assert_done_on_roll_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(roll));

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !done_clr) |=> tx_done);

    assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && s_q.phase != PH_IDLE && !roll) |=> $stable(s_q.phase));

endmodule

// File: tb/sentinel_uart_tx_tb.sv
`timescale 1ns/1ps
module sentinel_uart_tx_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          baud_tick = 1'b0;
    logic          wr_stb = 1'b0;
    logic [DW-1:0] wr_byte = '0;
    logic          wr_ninth = 1'b0;
    logic          nine_bit_mode = 1'b0;
    logic          done_clr = 1'b0;
    logic          txd;
    logic          tx_done;

    int          checks = 0;
    int          fails = 0;
    int unsigned tcnt = 0;

    always #2 clk = ~clk;

    sentinel_uart_tx #(.DATA_W(DW), .DIV_W(4)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .wr_stb       (wr_stb),
        .wr_byte      (wr_byte),
        .wr_ninth     (wr_ninth),
        .nine_bit_mode(nine_bit_mode),
        .done_clr     (done_clr),
        .txd          (txd),
        .tx_done      (tx_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected line level after the k-th rollover following the write
    function automatic logic exp_level(input logic [7:0] d, input logic nb,
                                       input logic m9, input int k);
        if (k <= 0) return 1'b1;
        if (k == 1) return 1'b0;
        if (k <= 9) return d[k-2];
        if (k == 10 && m9) return nb;
        return 1'b1;
    endfunction

    function automatic int frame_rolls(input logic m9);
        return m9 ? 11 : 10;
    endfunction

    // one clock with the given tick; returns whether it was a rollover
    task automatic cyc(input logic t, output bit rolled);
        baud_tick = t;
        @(posedge clk);
        rolled = t && (tcnt % 16 == 15);
        if (t) tcnt++;
        @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic nb, input logic m9,
                             input int dens, input bit noise, input bit hold_clr,
                             input bit roll_on_write);
        bit   r;
        int   k = 0;
        int   guard = 0;
        bit   steady = 1;
        logic prev;
        int   last = frame_rolls(m9);
        string fmt_req = m9 ? "R5" : "R4";
        if (roll_on_write) begin
            while (tcnt % 16 != 15) cyc(1'b1, r);
        end
        done_clr      = hold_clr;
        wr_stb        = 1'b1;
        wr_byte       = d;
        wr_ninth      = nb;
        nine_bit_mode = m9;
        cyc(roll_on_write ? 1'b1 : (($urandom % 100) < dens), r);
        wr_stb = 1'b0;
        check(txd == 1'b1, "R2", "line while waiting", int'(txd), 1);
        prev = txd;
        while (k < last && guard < 20000) begin
            guard++;
            if (noise) begin
                wr_stb        = (($urandom % 6) == 0);
                wr_byte       = 8'($urandom);
                wr_ninth      = 1'($urandom);
                nine_bit_mode = 1'($urandom);
            end
            cyc(($urandom % 100) < dens, r);
            wr_stb = 1'b0;
            if (r) begin
                k++;
                check(txd == exp_level(d, nb, m9, k), (k == 1) ? "R3" : fmt_req,
                      $sformatf("level after rollover %0d", k),
                      int'(txd), int'(exp_level(d, nb, m9, k)));
                if (k < last)
                    check(tx_done == 1'b0, "R6", "flag early", int'(tx_done), 0);
                else
                    check(tx_done == 1'b1, hold_clr ? "R7" : "R6",
                          "flag at final rollover", int'(tx_done), 1);
            end else if (txd !== prev) begin
                steady = 0;
            end
            prev = txd;
        end
        check(steady, "R3", "line moved off a boundary", int'(steady), 1);
        check(guard < 20000, "R3", "frame never finished", guard, 0);
        done_clr = 1'b0;
    endtask

    task automatic after_frame();
        bit r;
        int k = 0;
        bit idle_ok = 1;
        while (k < 2) begin
            cyc(1'($urandom), r);
            if (r) k++;
            if (txd !== 1'b1) idle_ok = 0;
        end
        check(idle_ok, "R8", "extra character after frame", int'(idle_ok), 1);
        check(tx_done == 1'b1, "R7", "flag held", int'(tx_done), 1);
        done_clr = 1'b1;
        cyc(1'b0, r);
        done_clr = 1'b0;
        check(tx_done == 1'b0, "R7", "flag after clear", int'(tx_done), 0);
        cyc(1'b0, r);
        check(tx_done == 1'b0, "R7", "flag stays clear", int'(tx_done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit r;
        void'($urandom(32'h1F2E_3D4C));
        @(negedge clk);
        repeat (3) @(negedge clk);
        check(txd == 1'b1, "R1", "line in reset", int'(txd), 1);
        check(tx_done == 1'b0, "R1", "flag in reset", int'(tx_done), 0);
        rst_n = 1'b1;
        cyc(1'b0, r);
        check(txd == 1'b1, "R1", "line after reset", int'(txd), 1);
        check(tx_done == 1'b0, "R1", "flag after reset", int'(tx_done), 0);

        // directed corners
        run_frame(8'hA5, 1'b0, 1'b0, 100, 0, 0, 0); after_frame();   // R4
        run_frame(8'h3C, 1'b1, 1'b1, 100, 0, 0, 0); after_frame();   // R5
        run_frame(8'h02, 1'b0, 1'b1, 70, 0, 0, 0);  after_frame();   // R5 end-pattern look-alike
        run_frame(8'h00, 1'b1, 1'b0, 60, 0, 0, 0);  after_frame();   // R4 all zero
        run_frame(8'hFF, 1'b0, 1'b1, 60, 0, 0, 0);  after_frame();   // R5 zero ninth
        run_frame(8'h5A, 1'b1, 1'b1, 50, 0, 0, 1);  after_frame();   // R3 write on rollover
        run_frame(8'hC3, 1'b0, 1'b0, 80, 0, 1, 0);  after_frame();   // R7 set beats clear
        run_frame(8'h81, 1'b1, 1'b0, 90, 1, 0, 0);  after_frame();   // R8 R9 stray writes
        run_frame(8'h7E, 1'b0, 1'b1, 90, 1, 0, 0);  after_frame();   // R8 R9 stray writes

        for (int i = 0; i < 40; i++) begin
            run_frame(8'($urandom), 1'($urandom), 1'($urandom),
                      30 + int'($urandom % 71), 1'($urandom), 1'($urandom % 8 == 0), 1'($urandom % 6 == 0));
            after_frame();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule